// File: doc/BRIEF.md
# Serial Port Receive Buffer

This block is the receive side of a synchronous serial port. A shift register clocked by the serial clock collects bits from the data line, beginning with the bit that arrives together with a frame sync pulse. The word is sent most significant bit first. Once the configured number of bits has arrived, the word goes to a holding register and a word-complete event crosses into the system clock domain. The system side then places the word in a two-entry first-in first-out buffer.

The system side reads the buffer through a valid/ready stream. `rx_valid` is high whenever the buffer holds a word, and `rx_data` shows the oldest word. A word leaves the buffer on each system clock edge where `rx_valid` and `rx_ready` are both high. The serial line cannot be stalled, so back-pressure does not reach it. If the consumer holds `rx_ready` low and both entries are full when a third word completes, the third word replaces the newer entry and a sticky overflow flag is set. The flag clears only when the port is disabled. Disabling the port also empties the buffer and resets the shifter.

The word length must be changed only while the port is disabled. The serial clock period must be at least four system clock periods.

Top module: `sport_rx_buffer`

## Requirements
- R1: `port_ready` goes high on the second rising `clk` edge at which `enable` is sampled high, and it is low again one edge after `enable` is sampled low. No serial activity is accepted while `port_ready` is low.
- R2: A word starts on a rising `sclk` edge where `rx_fs` is high, and `rx_sd` at that edge is the first bit. The word ends after `word_len`+1 bits (so `word_len` = 0 to 31 gives 1 to 32 bits), sent most significant bit first.
- R3: A word shorter than 32 bits appears right-justified in `rx_data`, with every bit above the word length equal to zero.
- R4: Bits that arrive after a word has completed and before the next frame sync are ignored and produce no word.
- R5: A completed word appears at the head of an empty buffer (`rx_valid` high) no more than five `clk` cycles after the `sclk` edge that carried its last bit.
- R6: `rx_valid` is high exactly when the buffer holds a word, and `rx_data` is then the oldest word. While `rx_ready` is low, `rx_data` stays unchanged. Asserting `rx_ready` while the buffer is empty has no effect.
- R7: The buffer holds two complete words and returns them in arrival order. Filling both entries does not set `overflow`.
- R8: When both entries are full and a third word completes with no read in the same cycle, the third word replaces the second entry, the first entry is kept, and `overflow` goes high.
- R9: `overflow` stays high through later reads and words until the port is disabled. Disabling clears `overflow` and empties the buffer, and re-enabling does not bring old words back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Port enable; low clears buffer, shifter and overflow |
| word_len | input | 5 | Word length minus one; change only while disabled |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| rx_sd | input | 1 | Serial data line |
| rx_fs | input | 1 | Frame sync; high with the first bit of a word |
| rx_data | output | 32 | Oldest buffered word, right-justified |
| rx_valid | output | 1 | Buffer is not empty |
| rx_ready | input | 1 | Consumer accepts `rx_data` on this edge |
| overflow | output | 1 | Sticky flag: a word replaced the second entry |
| port_ready | output | 1 | Port is enabled and able to receive |

## Verification
`port_ready` is a two-flop pipeline from `enable`, so the bench samples it on the falling `clk` edge after the first and after the second rising edge, expecting low and then high. A word takes a handful of system cycles to land after its last serial edge: two synchronizer stages plus one edge-detect and buffer-write stage. The bench therefore waits ten `clk` cycles after each serial word before it samples `rx_valid`, `rx_data` or `overflow`. The scoreboard monitor compares `rx_data` on falling `clk` edges where `rx_valid` and `rx_ready` are both high, which is the half cycle before the rising edge that pops the word.

// File: rtl/sprx_pkg.sv
package sprx_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned BUF_DEPTH  = 2;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/sprx_enable_ctl.sv
module sprx_enable_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic rdy
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      rdy  <= 1'b0;
    end else begin
      en_q <= enable;
      rdy  <= enable & en_q;
    end
  end

  // R1
  drop_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !rdy);

  // R1
  two_cycle_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> ($past(enable) && $past(en_q)));
endmodule

// File: rtl/sprx_shifter.sv
module sprx_shifter #(
  parameter int unsigned DATA_W = sprx_pkg::WORD_W,
  localparam int unsigned LEN_W = $clog2(DATA_W)
) (
  input  logic              sclk,
  input  logic              srst_n,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              sd,
  input  logic              fs,
  output logic [DATA_W-1:0] word_hold,
  output logic              word_tog
);
  logic [DATA_W-1:0] shreg;
  logic [LEN_W-1:0]  cnt;
  logic              active;
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] nxt;
  logic              last_bit;

  always_comb begin
    base     = fs ? '0 : shreg;
    nxt      = {base[DATA_W-2:0], sd};
    last_bit = fs ? (len_m1 == '0) : (active && (cnt == len_m1));
  end

  always_ff @(posedge sclk or negedge srst_n) begin
    if (!srst_n) begin
      shreg     <= '0;
      cnt       <= '0;
      active    <= 1'b0;
      word_hold <= '0;
      word_tog  <= 1'b0;
    end else if (fs || active) begin
      shreg <= nxt;
      if (last_bit) begin
        word_hold <= nxt;
        word_tog  <= ~word_tog;
        active    <= 1'b0;
        cnt       <= '0;
      end else begin
        active <= 1'b1;
        cnt    <= fs ? LEN_W'(1) : cnt + LEN_W'(1);
      end
    end
  end

  // R2
  bit_count_range_chk: assert property (@(posedge sclk) disable iff (!srst_n)
    active |-> (cnt <= len_m1));

  // R4
  idle_ignores_data_chk: assert property (@(posedge sclk) disable iff (!srst_n)
    (!active && !fs) |=> $stable(word_tog));
endmodule

// File: rtl/sprx_evt_sync.sv
module sprx_evt_sync #(
  parameter int unsigned STAGES = sprx_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tog_in,
  output logic pulse
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   chain <= '0;
    else if (clr) chain <= '0;
    else          chain <= {chain[STAGES-1:0], tog_in};
  end

  assign pulse = chain[STAGES] ^ chain[STAGES-1];

  // R5
  cleared_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pulse);
endmodule

// File: rtl/sprx_fifo2.sv
module sprx_fifo2 #(
  parameter int unsigned DATA_W = sprx_pkg::WORD_W,
  parameter int unsigned DEPTH  = sprx_pkg::BUF_DEPTH,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dvalid,
  input  logic              dready,
  output logic              ovf
);
  logic [DATA_W-1:0] mem  [DEPTH];
  logic [DATA_W-1:0] nmem [DEPTH];
  logic [CW-1:0]     count;
  logic [CW-1:0]     ncount;
  logic              pop;
  logic              set_ovf;

  assign pop    = dready && (count != '0);
  assign dvalid = (count != '0);
  assign dout   = mem[0];

  always_comb begin
    nmem    = mem;
    ncount  = count;
    set_ovf = 1'b0;
    if (pop) begin
      for (int i = 0; i < int'(DEPTH) - 1; i++) nmem[i] = mem[i+1];
      ncount = count - CW'(1);
    end
    if (push) begin
      if (ncount == CW'(DEPTH)) begin
        nmem[DEPTH-1] = din;
        set_ovf       = 1'b1;
      end else begin
        for (int i = 0; i < int'(DEPTH); i++)
          if (CW'(i) == ncount) nmem[i] = din;
        ncount = ncount + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (clr) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      count <= ncount;
      if (set_ovf) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    mem <= nmem;
  end

  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R8
  overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(push && !pop && (count == CW'(DEPTH))));

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);

  // R6
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && !dready) |=> $stable(dout));

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dvalid && dready && !push) |=> !dvalid);

  // R9
  disable_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!dvalid && !ovf));
endmodule

// File: rtl/sport_rx_buffer.sv
module sport_rx_buffer #(
  parameter int unsigned DATA_W      = sprx_pkg::WORD_W,
  parameter int unsigned DEPTH       = sprx_pkg::BUF_DEPTH,
  parameter int unsigned SYNC_STAGES = sprx_pkg::SYNC_DEPTH,
  localparam int unsigned LEN_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [LEN_W-1:0]  word_len,
  input  logic              sclk,
  input  logic              rx_sd,
  input  logic              rx_fs,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              overflow,
  output logic              port_ready
);
  logic              rdy;
  logic              srst_n;
  logic [DATA_W-1:0] hold_word;
  logic              hold_tog;
  logic              word_evt;

  sprx_enable_ctl u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .rdy    (rdy)
  );

  assign srst_n     = rst_n & rdy;
  assign port_ready = rdy;

  sprx_shifter #(.DATA_W(DATA_W)) u_shift (
    .sclk      (sclk),
    .srst_n    (srst_n),
    .len_m1    (word_len),
    .sd        (rx_sd),
    .fs        (rx_fs),
    .word_hold (hold_word),
    .word_tog  (hold_tog)
  );

  sprx_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!rdy),
    .tog_in (hold_tog),
    .pulse  (word_evt)
  );

  sprx_fifo2 #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!rdy),
    .push   (word_evt),
    .din    (hold_word),
    .dout   (rx_data),
    .dvalid (rx_valid),
    .dready (rx_ready),
    .ovf    (overflow)
  );

  // R1
  idle_port_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_ready |=> (!rx_valid && !overflow));
endmodule

// File: tb/sim_sport_rx_buffer.sv
module sim_sport_rx_buffer;
  localparam int CLK_PERIOD  = 10;
  localparam int SCLK_PERIOD = 80;

  logic        clk = 1'b0;
  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [4:0]  word_len = 5'd31;
  logic        rx_sd = 1'b0;
  logic        rx_fs = 1'b0;
  logic        rx_ready = 1'b0;
  logic [31:0] rx_data;
  logic        rx_valid;
  logic        overflow;
  logic        port_ready;

  int errors = 0;
  int checks = 0;
  logic [31:0] expq [$];
  string       cur_req = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(SCLK_PERIOD/2) sclk = ~sclk;

  sport_rx_buffer u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .word_len(word_len),
    .sclk(sclk), .rx_sd(rx_sd), .rx_fs(rx_fs),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .overflow(overflow), .port_ready(port_ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: serial word, MSB first, frame sync with first bit
  task automatic send_word(input logic [31:0] val, input int len, input bit expect_it);
    if (expect_it) expq.push_back(val & ((len == 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1)));
    for (int b = len - 1; b >= 0; b--) begin
      @(negedge sclk);
      rx_fs = (b == len - 1);
      rx_sd = val[b];
    end
    @(negedge sclk);
    rx_fs = 1'b0;
    rx_sd = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reconfig(input logic [4:0] len_m1);
    @(negedge clk);
    enable = 1'b0;
    wait_clk(3);
    word_len = len_m1;
    enable = 1'b1;
    wait_clk(4);
  endtask

  // monitor: compare each word taken by the consumer
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, cur_req, rx_data, 32'h0);
      end else begin
        logic [31:0] e;
        e = expq.pop_front();
        check(rx_data == e, cur_req, rx_data, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(1);
    check(!rx_valid, "R6 reset valid", {31'b0, rx_valid}, 32'h0);
    check(!overflow, "R9 reset overflow", {31'b0, overflow}, 32'h0);
    check(!port_ready, "R1 reset ready", {31'b0, port_ready}, 32'h0);

    // R1: two-edge arm
    enable = 1'b1;
    @(negedge clk);
    check(!port_ready, "R1 one edge", {31'b0, port_ready}, 32'h0);
    @(negedge clk);
    check(port_ready, "R1 two edges", {31'b0, port_ready}, 32'h1);

    // R2, R5: full-width words drained by consumer
    rx_ready = 1'b1;
    cur_req = "R2";
    send_word(32'hA5C3_1E7F, 32, 1'b1);
    wait_clk(10);
    check(expq.size() == 0, "R5 word landed", expq.size(), 0);
    send_word(32'h8000_0001, 32, 1'b1);
    wait_clk(10);
    check(expq.size() == 0, "R5 second landed", expq.size(), 0);

    // R3, R4: 8-bit word, then stray bits without frame sync
    reconfig(5'd7);
    cur_req = "R3";
    send_word(32'hFFFF_FFC6, 8, 1'b1);
    wait_clk(10);
    check(expq.size() == 0, "R3 short word", expq.size(), 0);
    cur_req = "R4";
    for (int k = 0; k < 12; k++) begin
      @(negedge sclk);
      rx_sd = 1'b1;
    end
    @(negedge sclk);
    rx_sd = 1'b0;
    wait_clk(10);
    check(!rx_valid, "R4 stray bits", {31'b0, rx_valid}, 32'h0);

    // R2: one-bit words back to back
    reconfig(5'd0);
    cur_req = "R2";
    send_word(32'h1, 1, 1'b1);
    send_word(32'h0, 1, 1'b1);
    send_word(32'h1, 1, 1'b1);
    wait_clk(10);
    check(expq.size() == 0, "R2 one-bit words", expq.size(), 0);

    // R6, R7, R8: fill without reading, then overflow
    reconfig(5'd15);
    rx_ready = 1'b0;
    send_word(32'h1111, 16, 1'b1);
    wait_clk(10);
    check(rx_valid && rx_data == 32'h1111, "R6 head shown", rx_data, 32'h1111);
    send_word(32'h2222, 16, 1'b0);
    wait_clk(10);
    check(!overflow, "R7 two held", {31'b0, overflow}, 32'h0);
    check(rx_data == 32'h1111, "R6 head stable", rx_data, 32'h1111);
    send_word(32'h3333, 16, 1'b1);
    wait_clk(10);
    check(overflow, "R8 overflow set", {31'b0, overflow}, 32'h1);
    cur_req = "R8";
    rx_ready = 1'b1;
    wait_clk(6);
    check(expq.size() == 0, "R8 order kept", expq.size(), 0);
    check(!rx_valid, "R6 drained", {31'b0, rx_valid}, 32'h0);
    check(overflow, "R9 sticky after read", {31'b0, overflow}, 32'h1);
    send_word(32'h4444, 16, 1'b1);
    wait_clk(10);
    check(overflow, "R9 sticky after word", {31'b0, overflow}, 32'h1);

    // R9: disable clears held word and overflow
    rx_ready = 1'b0;
    send_word(32'h5555, 16, 1'b0);
    wait_clk(10);
    check(rx_valid, "R9 word held", {31'b0, rx_valid}, 32'h1);
    enable = 1'b0;
    wait_clk(2);
    check(!port_ready, "R1 disabled", {31'b0, port_ready}, 32'h0);
    check(!overflow, "R9 cleared", {31'b0, overflow}, 32'h0);
    check(!rx_valid, "R9 emptied", {31'b0, rx_valid}, 32'h0);
    enable = 1'b1;
    wait_clk(4);
    check(!rx_valid && !overflow, "R9 re-enable clean", {30'b0, rx_valid, overflow}, 32'h0);
    check(expq.size() == 0, "R7 scoreboard empty", expq.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule